// File: doc/BRIEF.md
# Level-1 Latency Buffer and Event Formatter

The block stores a continuous stream of multi-channel samples in a ring that provides the level-1 trigger delay. Each time a level-1 accept arrives, it copies a fixed window of samples for every channel out of the ring and into one slot of a small event store. Completed slots are then sent toward a data-collection link as framed words, one event at a time and in order, under a valid/ready handshake.

All channels are written as one wide row per valid sample. Each accepted event holds 12 consecutive rows, which is two crossings at six samples per crossing. A programmable latency chooses how far back in the ring the window starts. The window start is then moved back onto a crossing boundary. Several events can wait in the store while an earlier one is still being sent.

Top module: `l1_latency_buffer`

## Requirements
- R1: After reset, `out_valid_o`, `busy_o` and `drop_count_o` are all zero.
- R2: Each event is framed as three parts in this order. First comes a header word carrying a 16-bit event number, which starts at 0 and increases by one for each event sent; `out_sop_o` is high on the header. Next come N_CH*12 data words, each with the sample in bits [11:0] and zeros above. Last comes a trailer word equal to N_CH*12, with `out_eop_o` high.
- R3: Samples are ordered by age; the last sample written before the accept edge has age 1. The nominal window start is the sample of age equal to the effective latency. The window then moves back to the nearest sample at or before that point whose crossing phase is 0, and covers 12 consecutive samples from there. Data words are sent channel-major: all 12 samples of channel 0 first, oldest first.
- R4: The effective latency is `latency_i` clamped to the range [13, 244]. It is sampled on the accept edge.
- R5: Up to 4 events may be held, counting the one being captured. `busy_o` is high while all 4 are held. An accept that arrives while `busy_o` is high is dropped.
- R6: A capture takes 12 cycles. Any accept that arrives during those 12 cycles is dropped.
- R7: `drop_count_o` counts every dropped accept. It is 8 bits wide and saturates at 255.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output word, `out_sop_o` and `out_eop_o` are held unchanged.
- R9: Every event that is taken is sent, in the order of its accepts, with no words lost, repeated or reordered.
- R10: A row is written only when `smp_valid_i` is high. The crossing phase of a written row is 0 if `xing_i` is high; otherwise it is the previous phase plus one, wrapping after 5. The phase of the row before the first write counts as 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample and output clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_data_i | input | N_CH*12 | One 12-bit sample per channel, channel 0 in the low bits |
| smp_valid_i | input | 1 | Writes the sample row into the ring |
| xing_i | input | 1 | Marks the current sample row as the first of a crossing |
| l1_accept_i | input | 1 | Level-1 accept pulse |
| latency_i | input | 8 | Trigger latency in samples |
| out_data_o | output | 16 | Framed output word |
| out_valid_o | output | 1 | Output word is valid |
| out_sop_o | output | 1 | Marks the header word |
| out_eop_o | output | 1 | Marks the trailer word |
| out_ready_i | input | 1 | Downstream accepts the word |
| busy_o | output | 1 | Event store is full |
| drop_count_o | output | 8 | Saturating count of dropped accepts |

## Verification
An accept driven before a rising edge takes effect at that edge. `busy_o` and `drop_count_o` reflect the accept one edge later, so the bench reads them at the falling edge after that. The expected window is worked out from the bench's own history of samples at the moment the accept is driven, so samples that arrive later cannot affect it. Output words are observed at each falling edge together with the ready value just driven, which is the pair that the next rising edge acts on. A held word is compared against the value seen at the previous falling edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FMT_IDLE,
    FMT_HDR,
    FMT_DATA,
    FMT_TRL
  } fmt_state_e;
endpackage

// File: rtl/tlb_ring.sv
// Sample delay ring; DEPTH must be a power of two.
module tlb_ring #(
  parameter int ROW_W     = 576,
  parameter int DEPTH     = 256,
  parameter int AW        = 8,
  parameter int CROSS_DIV = 6,
  parameter int PH_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             xing_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [PH_W-1:0]  last_ph_o
);
  logic [ROW_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_row_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      ph_q     <= PH_W'(CROSS_DIV - 1);
    end else if (wr_en_i) begin
      wr_ptr_q <= wr_ptr_q + AW'(1);
      if (xing_i || ph_q == PH_W'(CROSS_DIV - 1)) ph_q <= '0;
      else ph_q <= ph_q + PH_W'(1);
    end
  end

  assign rd_row_o  = mem_q[rd_addr_i];
  assign wr_ptr_o  = wr_ptr_q;
  assign last_ph_o = ph_q;

  p_ptr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_o));
endmodule

// File: rtl/tlb_capture.sv
module tlb_capture #(
  parameter int DEPTH     = 256,
  parameter int AW        = 8,
  parameter int WIN       = 12,
  parameter int CROSS_DIV = 6,
  parameter int PH_W      = 3,
  parameter int QD        = 4,
  parameter int SLOT_W    = 2,
  parameter int ROWI_W    = 4,
  parameter int LAT_W     = 8,
  parameter int DROP_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [LAT_W-1:0]  latency_i,
  input  logic [AW-1:0]     wr_ptr_i,
  input  logic [PH_W-1:0]   last_ph_i,
  input  logic              evt_done_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              st_we_o,
  output logic [SLOT_W-1:0] st_slot_o,
  output logic [ROWI_W-1:0] st_row_o,
  output logic              pending_o,
  output logic              busy_o,
  output logic [DROP_W-1:0] drop_count_o
);
  localparam int LAT_MIN = WIN + 1;
  localparam int LAT_MAX = DEPTH - WIN;
  localparam int OFFS    = CROSS_DIV * ((DEPTH + CROSS_DIV - 1) / CROSS_DIV);
  localparam int XW      = AW + 2;
  localparam int CNT_W   = $clog2(QD + 1);

  logic [LAT_W-1:0]  lat_eff;
  logic [XW-1:0]     ph_sum;
  logic [PH_W-1:0]   ph_nom;
  logic [AW-1:0]     age, start_addr;
  logic              cap_busy_q, full, take, commit;
  logic [ROWI_W-1:0] cap_row_q;
  logic [AW-1:0]     cap_addr_q;
  logic [SLOT_W-1:0] wr_slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DROP_W-1:0] drop_q;

  always_comb begin
    if (latency_i < LAT_W'(LAT_MIN))      lat_eff = LAT_W'(LAT_MIN);
    else if (latency_i > LAT_W'(LAT_MAX)) lat_eff = LAT_W'(LAT_MAX);
    else                                  lat_eff = latency_i;
    // phase of the nominal start row, counted back from the newest row
    ph_sum     = XW'(OFFS) + XW'(last_ph_i) + XW'(1) - XW'(lat_eff);
    ph_nom     = PH_W'(ph_sum % XW'(CROSS_DIV));
    age        = AW'(lat_eff) + AW'(ph_nom);
    start_addr = wr_ptr_i - age;
  end

  assign full   = (cnt_q + CNT_W'(cap_busy_q)) == CNT_W'(QD);
  assign take   = accept_i && !cap_busy_q && !full;
  assign commit = cap_busy_q && (cap_row_q == ROWI_W'(WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_busy_q <= 1'b0;
      cap_row_q  <= '0;
      cap_addr_q <= '0;
      wr_slot_q  <= '0;
      cnt_q      <= '0;
      drop_q     <= '0;
    end else begin
      if (take) begin
        cap_busy_q <= 1'b1;
        cap_row_q  <= '0;
        cap_addr_q <= start_addr;
      end else if (cap_busy_q) begin
        cap_row_q  <= cap_row_q + ROWI_W'(1);
        cap_addr_q <= cap_addr_q + AW'(1);
        if (commit) cap_busy_q <= 1'b0;
      end
      if (commit) begin
        if (wr_slot_q == SLOT_W'(QD - 1)) wr_slot_q <= '0;
        else wr_slot_q <= wr_slot_q + SLOT_W'(1);
      end
      cnt_q <= cnt_q + CNT_W'(commit) - CNT_W'(evt_done_i);
      if (accept_i && !take && drop_q != '1) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign rd_addr_o    = cap_addr_q;
  assign st_we_o      = cap_busy_q;
  assign st_slot_o    = wr_slot_q;
  assign st_row_o     = cap_row_q;
  assign pending_o    = cnt_q != '0;
  assign busy_o       = full;
  assign drop_count_o = drop_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(QD));
  p_full_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && busy_o) |=> !(st_we_o && st_row_o == '0));
  p_capture_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_o && st_row_o != ROWI_W'(WIN - 1)) |=> st_we_o);
  p_drop_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && busy_o && drop_count_o != '1) |=> drop_count_o == $past(drop_count_o) + DROP_W'(1));
  p_drop_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_count_o == '1) |=> (drop_count_o == '1));
endmodule

// File: rtl/tlb_evt_store.sv
module tlb_evt_store #(
  parameter int ROW_W  = 576,
  parameter int QD     = 4,
  parameter int WIN    = 12,
  parameter int SLOT_W = 2,
  parameter int ROWI_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wslot_i,
  input  logic [ROWI_W-1:0] wrow_i,
  input  logic [ROW_W-1:0]  wdata_i,
  input  logic [SLOT_W-1:0] rslot_i,
  input  logic [ROWI_W-1:0] rrow_i,
  output logic [ROW_W-1:0]  rdata_o
);
  localparam int ENTRIES = QD * WIN;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [ROW_W-1:0] mem_q [ENTRIES];
  logic [IDX_W-1:0] widx, ridx;

  assign widx = IDX_W'(wslot_i) * IDX_W'(WIN) + IDX_W'(wrow_i);
  assign ridx = IDX_W'(rslot_i) * IDX_W'(WIN) + IDX_W'(rrow_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx];

  always_comb begin
    if (we_i) p_wrow_range_r3: assert (wrow_i < ROWI_W'(WIN));
  end
endmodule

// File: rtl/tlb_fmt.sv
module tlb_fmt
  import tlb_pkg::*;
#(
  parameter int N_CH   = 48,
  parameter int SW     = 12,
  parameter int WIN    = 12,
  parameter int QD     = 4,
  parameter int SLOT_W = 2,
  parameter int ROWI_W = 4,
  parameter int CH_W   = 6,
  parameter int EVN_W  = 16,
  parameter int ROW_W  = 576
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pending_i,
  input  logic [ROW_W-1:0]  rdata_i,
  output logic [SLOT_W-1:0] rslot_o,
  output logic [ROWI_W-1:0] rrow_o,
  output logic [EVN_W-1:0]  out_data_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  input  logic              out_ready_i,
  output logic              evt_done_o
);
  fmt_state_e        state_q;
  logic [CH_W-1:0]   ch_q;
  logic [ROWI_W-1:0] row_q;
  logic [EVN_W-1:0]  evn_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SW-1:0]     smp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FMT_IDLE;
      ch_q    <= '0;
      row_q   <= '0;
      evn_q   <= '0;
      slot_q  <= '0;
    end else begin
      case (state_q)
        FMT_IDLE: if (pending_i) state_q <= FMT_HDR;
        FMT_HDR: if (out_ready_i) begin
          state_q <= FMT_DATA;
          ch_q    <= '0;
          row_q   <= '0;
        end
        FMT_DATA: if (out_ready_i) begin
          if (row_q == ROWI_W'(WIN - 1)) begin
            row_q <= '0;
            if (ch_q == CH_W'(N_CH - 1)) state_q <= FMT_TRL;
            else ch_q <= ch_q + CH_W'(1);
          end else begin
            row_q <= row_q + ROWI_W'(1);
          end
        end
        FMT_TRL: if (out_ready_i) begin
          state_q <= FMT_IDLE;
          evn_q   <= evn_q + EVN_W'(1);
          if (slot_q == SLOT_W'(QD - 1)) slot_q <= '0;
          else slot_q <= slot_q + SLOT_W'(1);
        end
        default: state_q <= FMT_IDLE;
      endcase
    end
  end

  assign smp = rdata_i[int'(ch_q)*SW +: SW];

  always_comb begin
    case (state_q)
      FMT_HDR:  out_data_o = evn_q;
      FMT_DATA: out_data_o = EVN_W'(smp);
      FMT_TRL:  out_data_o = EVN_W'(N_CH * WIN);
      default:  out_data_o = '0;
    endcase
  end

  assign out_valid_o = state_q != FMT_IDLE;
  assign out_sop_o   = state_q == FMT_HDR;
  assign out_eop_o   = state_q == FMT_TRL;
  assign evt_done_o  = (state_q == FMT_TRL) && out_ready_i;
  assign rslot_o     = slot_q;
  assign rrow_o      = row_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sop_o) && $stable(out_eop_o)));
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o && !pending_i) |=> !out_valid_o);
endmodule

// File: rtl/l1_latency_buffer.sv
module l1_latency_buffer #(
  parameter int N_CH      = 48,
  parameter int SW        = 12,
  parameter int DEPTH     = 256,
  parameter int WIN       = 12,
  parameter int CROSS_DIV = 6,
  parameter int QD        = 4,
  parameter int LAT_W     = 8,
  parameter int EVN_W     = 16,
  parameter int DROP_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CH*SW-1:0]   smp_data_i,
  input  logic                 smp_valid_i,
  input  logic                 xing_i,
  input  logic                 l1_accept_i,
  input  logic [LAT_W-1:0]     latency_i,
  output logic [EVN_W-1:0]     out_data_o,
  output logic                 out_valid_o,
  output logic                 out_sop_o,
  output logic                 out_eop_o,
  input  logic                 out_ready_i,
  output logic                 busy_o,
  output logic [DROP_W-1:0]    drop_count_o
);
  localparam int ROW_W  = N_CH * SW;
  localparam int AW     = $clog2(DEPTH);
  localparam int PH_W   = $clog2(CROSS_DIV);
  localparam int SLOT_W = (QD > 1) ? $clog2(QD) : 1;
  localparam int ROWI_W = $clog2(WIN);
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [ROW_W-1:0]  ring_rd, st_rd;
  logic [AW-1:0]     ring_addr, wr_ptr;
  logic [PH_W-1:0]   last_ph;
  logic              st_we, pending, evt_done;
  logic [SLOT_W-1:0] st_wslot, st_rslot;
  logic [ROWI_W-1:0] st_wrow, st_rrow;

  tlb_ring #(
    .ROW_W(ROW_W), .DEPTH(DEPTH), .AW(AW), .CROSS_DIV(CROSS_DIV), .PH_W(PH_W)
  ) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(smp_valid_i), .xing_i(xing_i),
    .wr_row_i(smp_data_i), .rd_addr_i(ring_addr), .rd_row_o(ring_rd),
    .wr_ptr_o(wr_ptr), .last_ph_o(last_ph)
  );

  tlb_capture #(
    .DEPTH(DEPTH), .AW(AW), .WIN(WIN), .CROSS_DIV(CROSS_DIV), .PH_W(PH_W),
    .QD(QD), .SLOT_W(SLOT_W), .ROWI_W(ROWI_W), .LAT_W(LAT_W), .DROP_W(DROP_W)
  ) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(l1_accept_i), .latency_i(latency_i),
    .wr_ptr_i(wr_ptr), .last_ph_i(last_ph), .evt_done_i(evt_done),
    .rd_addr_o(ring_addr), .st_we_o(st_we), .st_slot_o(st_wslot), .st_row_o(st_wrow),
    .pending_o(pending), .busy_o(busy_o), .drop_count_o(drop_count_o)
  );

  tlb_evt_store #(
    .ROW_W(ROW_W), .QD(QD), .WIN(WIN), .SLOT_W(SLOT_W), .ROWI_W(ROWI_W)
  ) u_store (
    .clk_i(clk_i), .we_i(st_we), .wslot_i(st_wslot), .wrow_i(st_wrow),
    .wdata_i(ring_rd), .rslot_i(st_rslot), .rrow_i(st_rrow), .rdata_o(st_rd)
  );

  tlb_fmt #(
    .N_CH(N_CH), .SW(SW), .WIN(WIN), .QD(QD), .SLOT_W(SLOT_W), .ROWI_W(ROWI_W),
    .CH_W(CH_W), .EVN_W(EVN_W), .ROW_W(ROW_W)
  ) u_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pending_i(pending), .rdata_i(st_rd),
    .rslot_o(st_rslot), .rrow_o(st_rrow), .out_data_o(out_data_o),
    .out_valid_o(out_valid_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .out_ready_i(out_ready_i), .evt_done_o(evt_done)
  );

  p_sop_eop_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_sop_o && out_eop_o));
endmodule

// File: tb/l1_latency_buffer_tb.sv
`timescale 1ns/1ps
module l1_latency_buffer_tb;
  localparam int N_CH = 48;
  localparam int SW   = 12;
  localparam int WIN  = 12;
  localparam int ROW_W = N_CH * SW;
  localparam int HN   = 1024;
  localparam int MAXE = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ROW_W-1:0] smp_data_i = '0;
  logic smp_valid_i = 1'b0, xing_i = 1'b0, l1_accept_i = 1'b0, out_ready_i = 1'b0;
  logic [7:0] latency_i = '0;
  logic [15:0] out_data_o;
  logic out_valid_o, out_sop_o, out_eop_o, busy_o;
  logic [7:0] drop_count_o;

  always #2 clk = ~clk;

  l1_latency_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_data_i(smp_data_i), .smp_valid_i(smp_valid_i),
    .xing_i(xing_i), .l1_accept_i(l1_accept_i), .latency_i(latency_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_sop_o(out_sop_o),
    .out_eop_o(out_eop_o), .out_ready_i(out_ready_i), .busy_o(busy_o),
    .drop_count_o(drop_count_o)
  );

  int checks = 0, fails = 0;
  logic [ROW_W-1:0] hist [HN];
  int hph [HN];
  int wcount = 0, ph = 5;
  logic [ROW_W-1:0] ev_rows [MAXE][WIN];
  int n_exp = 0, n_got = 0, mon_pos = 0;
  int ready_mode = 0;
  bit hold_pend = 0;
  logic [17:0] hold_word;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_lat(input int l);
    if (l < 13) return 13;
    if (l > 244) return 244;
    return l;
  endfunction

  task automatic tick(input bit acc, input int lat, input bit take);
    @(negedge clk);
    case (ready_mode)
      0: out_ready_i = 1'b0;
      1: out_ready_i = 1'b1;
      default: out_ready_i = ($urandom % 4) != 0;
    endcase
    if (hold_pend) // R8
      chk(out_valid_o && {out_sop_o, out_eop_o, out_data_o} == hold_word, "R8", "held word",
          int'({out_valid_o, out_sop_o, out_eop_o, out_data_o}), int'({1'b1, hold_word}));
    hold_pend = out_valid_o && !out_ready_i;
    hold_word = {out_sop_o, out_eop_o, out_data_o};
    if (out_valid_o && out_ready_i) begin
      int e = n_got;
      if (e >= n_exp) begin
        chk(0, "R9", "unexpected word", int'(out_data_o), -1);
      end else if (mon_pos == 0) begin
        chk({out_sop_o, out_eop_o, out_data_o} == {2'b10, 16'(e)}, "R2", "header",
            int'({out_sop_o, out_eop_o, out_data_o}), int'({2'b10, 16'(e)}));
        mon_pos++;
      end else if (mon_pos <= N_CH * WIN) begin
        int d = mon_pos - 1;
        int c = d / WIN;
        int s = d % WIN;
        logic [15:0] ex = {4'b0, ev_rows[e][s][c*SW +: SW]};
        chk({out_sop_o, out_eop_o, out_data_o} == {2'b00, ex}, "R3 R4 R10", "data word",
            int'({out_sop_o, out_eop_o, out_data_o}), int'(ex));
        mon_pos++;
      end else begin
        chk({out_sop_o, out_eop_o, out_data_o} == {2'b01, 16'(N_CH * WIN)}, "R2", "trailer",
            int'({out_sop_o, out_eop_o, out_data_o}), int'({2'b01, 16'(N_CH * WIN)}));
        mon_pos = 0;
        n_got++;
      end
    end
    l1_accept_i = acc;
    latency_i = 8'(lat);
    if (acc && take) begin
      int idx = wcount - clamp_lat(lat);
      while (hph[idx % HN] != 0) idx--;
      for (int s = 0; s < WIN; s++) ev_rows[n_exp][s] = hist[(idx + s) % HN];
      n_exp++;
    end
    smp_valid_i = ($urandom % 8) != 0;
    xing_i = 1'b0;
    if (smp_valid_i) begin
      for (int c = 0; c < N_CH; c++) smp_data_i[c*SW +: SW] = 12'($urandom);
      ph = (ph == 5) ? 0 : ph + 1;
      xing_i = (ph == 0);
      hist[wcount % HN] = smp_data_i;
      hph[wcount % HN] = ph;
      wcount++;
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done_flag) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'd20250309));
    repeat (3) @(negedge clk);
    chk(out_valid_o == 0 && busy_o == 0 && drop_count_o == 0, "R1", "reset outputs",
        int'({out_valid_o, busy_o, drop_count_o}), 0);
    rst_ni = 1'b1;
    ready_mode = 0;
    repeat (300) tick(0, 0, 0);
    // directed: capture overlap drop
    tick(1, 0, 1);
    repeat (3) tick(0, 0, 0);
    tick(1, 100, 0);
    tick(0, 0, 0);
    chk(drop_count_o == 1, "R6", "drop during capture", int'(drop_count_o), 1);
    repeat (20) tick(0, 0, 0);
    tick(1, 255, 1);
    repeat (20) tick(0, 0, 0);
    tick(1, 13, 1);
    repeat (20) tick(0, 0, 0);
    tick(1, 244, 1);
    repeat (2) tick(0, 0, 0);
    chk(busy_o == 1, "R5", "busy with four held", int'(busy_o), 1);
    repeat (15) tick(0, 0, 0);
    tick(1, 50, 0);
    tick(0, 0, 0);
    chk(drop_count_o == 2, "R5", "drop when full", int'(drop_count_o), 2);
    chk(busy_o == 1, "R5", "busy still full", int'(busy_o), 1);
    repeat (260) tick(1, 50, 0);
    tick(0, 0, 0);
    chk(drop_count_o == 255, "R7", "drop saturates", int'(drop_count_o), 255);
    ready_mode = 2;
    while (n_got < n_exp) tick(0, 0, 0);
    repeat (3) tick(0, 0, 0);
    chk(busy_o == 0, "R5", "busy clears after drain", int'(busy_o), 0);
    // random phase
    gap = 0;
    while (n_exp < 18) begin
      if (gap >= 14 && (n_exp - n_got) < 4 && ($urandom % 4) == 0) begin
        tick(1, int'($urandom % 256), 1);
        gap = 0;
      end else begin
        tick(0, 0, 0);
        gap++;
      end
    end
    while (n_got < n_exp) tick(0, 0, 0);
    repeat (5) tick(0, 0, 0);
    chk(n_got == n_exp, "R9", "all events sent", n_got, n_exp);
    chk(drop_count_o == 255, "R7", "count held at max", int'(drop_count_o), 255);
    chk(out_valid_o == 0 && busy_o == 0, "R9", "idle at end",
        int'({out_valid_o, busy_o}), 0);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule